// File: doc/BRIEF.md
# Dual Gated 2-to-4 Decoder

This block holds two 1-of-4 decoder sections, "a" and "b", that share one binary address. Each section drives four active-low outputs. When its enable gate is satisfied, exactly one output is low. Section "a" has one active-high gate input and one active-low gate input. A data stream fed into either of those inputs comes out at the addressed output either true or inverted. Section "b" has two active-low gate inputs. The block is purely combinational and holds no state.

The output style is set by a static input. In push-pull style each output drives 0 or 1. In open-drain style each output either pulls low or releases. This is expressed as a value bit plus a per-output drive enable, which a pad cell turns into a real high-impedance state. With released outputs tied together and a pull-up, the shared net gives the AND of the selected active-low minterms.

A second static input selects eight-way operation. In that mode the gate wiring used for 1-of-8 decoding is made inside the block. The active-high input of "a" becomes the third address bit and the active-low input of "a" becomes a common enable. Both also feed the gate of "b". The separate "b" gate inputs are then ignored.

Top module: `dual_dec2to4`

## Requirements
- R1: With section "a" enabled in push-pull style, output index equal to `addr_i` (bit 0 = LSB, bit 1 = MSB) is 0 and the other three are 1; the same holds for section "b".
- R2: Outside eight-way mode, section "a" is enabled only when `ga_hi_i` = 1 and `ga_lo_ni` = 0.
- R3: Outside eight-way mode, section "b" is enabled only when `gb0_ni` = 0 and `gb1_ni` = 0.
- R4: A disabled section presents all four outputs high (push-pull: value 1; open-drain: released), whatever the address.
- R5: With `od_i` = 0, every drive-enable bit of both sections is 1.
- R6: With `od_i` = 1, every value bit is 0 and a drive-enable bit is 1 only on a selected output, so nothing is ever driven high.
- R7: With `wide_i` = 1, `ga_hi_i` acts as address bit 2 and `ga_lo_ni` as the common active-low enable: bit 2 = 1 selects section "a", bit 2 = 0 selects section "b", and `gb0_ni`/`gb1_ni` have no effect.
- R8: With `wide_i` = 1, the eight resolved outputs (value where driven, 1 where released) contain exactly one 0 when `ga_lo_ni` = 0 and no 0 when `ga_lo_ni` = 1.
- R9: Outputs depend only on present inputs: applying the same input combination in any order gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | ADDR_W | Shared binary address |
| ga_hi_i | input | 1 | Section "a" active-high gate; address bit 2 in eight-way mode |
| ga_lo_ni | input | 1 | Section "a" active-low gate; common enable in eight-way mode |
| gb0_ni | input | 1 | Section "b" first active-low gate |
| gb1_ni | input | 1 | Section "b" second active-low gate |
| od_i | input | 1 | 1 = open-drain style, 0 = push-pull |
| wide_i | input | 1 | 1 = eight-way decode mode |
| a_val_o | output | 2**ADDR_W | Section "a" output values |
| a_drv_o | output | 2**ADDR_W | Section "a" drive enables |
| b_val_o | output | 2**ADDR_W | Section "b" output values |
| b_drv_o | output | 2**ADDR_W | Section "b" drive enables |

## Verification
Open-drain style and eight-way decoding can be active in the same input state. In that case, which section owns the single low output depends on the gate rerouting, and whether the output reads low depends on the drive enable rather than the value. The bench sweeps every combination of address, the four gate inputs, style and mode in ascending order and again in descending order. It resolves the outputs with a pull-up model and counts the zeros across all eight outputs. Each section is also compared bit for bit against a one-hot model derived from the requirements.

// File: rtl/dual_dec2to4_pkg.sv
package dual_dec2to4_pkg;
  typedef enum logic {
    STYLE_PUSH_PULL  = 1'b0,
    STYLE_OPEN_DRAIN = 1'b1
  } out_style_e;

  localparam int unsigned GATE_N = 2;
  // gate bit polarity masks: 1 = active-high input
  localparam logic [GATE_N-1:0] GATE_A_HI_MASK = 2'b01;
  localparam logic [GATE_N-1:0] GATE_B_HI_MASK = 2'b00;
endpackage

// File: rtl/dd_en_gate.sv
module dd_en_gate #(
  parameter int unsigned       N_IN    = 2,
  parameter logic [N_IN-1:0]   HI_MASK = '0
) (
  input  logic [N_IN-1:0] gate_i,
  output logic            on_o
);
  logic [N_IN-1:0] term;

  for (genvar i = 0; i < N_IN; i++) begin : g_term
    if (HI_MASK[i]) begin : g_hi
      assign term[i] = gate_i[i];
    end else begin : g_lo
      assign term[i] = ~gate_i[i];
    end
  end

  assign on_o = &term;
endmodule

// File: rtl/dd_dec_sect.sv
module dd_dec_sect #(
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned N_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              on_i,
  output logic [N_OUT-1:0]  lvl_no
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign lvl_no[i] = ~(on_i && (addr_i == ADDR_W'(i)));
  end
endmodule

// File: rtl/dd_out_stage.sv
module dd_out_stage
  import dual_dec2to4_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] lvl_ni,
  input  out_style_e   style_i,
  output logic [N-1:0] val_o,
  output logic [N-1:0] drv_o
);
  always_comb begin
    if (style_i == STYLE_OPEN_DRAIN) begin
      val_o = '0;
      drv_o = ~lvl_ni;   // pull only where selected
    end else begin
      val_o = lvl_ni;
      drv_o = '1;
    end
  end
endmodule

// File: rtl/dual_dec2to4.sv
module dual_dec2to4
  import dual_dec2to4_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned N_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ga_hi_i,
  input  logic              ga_lo_ni,
  input  logic              gb0_ni,
  input  logic              gb1_ni,
  input  logic              od_i,
  input  logic              wide_i,
  output logic [N_OUT-1:0]  a_val_o,
  output logic [N_OUT-1:0]  a_drv_o,
  output logic [N_OUT-1:0]  b_val_o,
  output logic [N_OUT-1:0]  b_drv_o
);
  logic [GATE_N-1:0] gate_a, gate_b;
  logic              on_a, on_b;
  logic [N_OUT-1:0]  lvl_a_n, lvl_b_n;
  out_style_e        style;

  assign style  = out_style_e'(od_i);
  assign gate_a = {ga_lo_ni, ga_hi_i};
  // eight-way: bit 2 and common enable both land on the b gate
  assign gate_b = wide_i ? {ga_lo_ni, ga_hi_i} : {gb1_ni, gb0_ni};

  dd_en_gate #(.N_IN(GATE_N), .HI_MASK(GATE_A_HI_MASK)) u_gate_a (
    .gate_i (gate_a),
    .on_o   (on_a)
  );

  dd_en_gate #(.N_IN(GATE_N), .HI_MASK(GATE_B_HI_MASK)) u_gate_b (
    .gate_i (gate_b),
    .on_o   (on_b)
  );

  dd_dec_sect #(.ADDR_W(ADDR_W)) u_sect_a (
    .addr_i (addr_i),
    .on_i   (on_a),
    .lvl_no (lvl_a_n)
  );

  dd_dec_sect #(.ADDR_W(ADDR_W)) u_sect_b (
    .addr_i (addr_i),
    .on_i   (on_b),
    .lvl_no (lvl_b_n)
  );

  dd_out_stage #(.N(N_OUT)) u_out_a (
    .lvl_ni  (lvl_a_n),
    .style_i (style),
    .val_o   (a_val_o),
    .drv_o   (a_drv_o)
  );

  dd_out_stage #(.N(N_OUT)) u_out_b (
    .lvl_ni  (lvl_b_n),
    .style_i (style),
    .val_o   (b_val_o),
    .drv_o   (b_drv_o)
  );
endmodule

// File: rtl/dual_dec2to4_chk.sv
module dual_dec2to4_chk #(
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned N_OUT = 1 << ADDR_W
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic              ga_hi_i,
  input logic              ga_lo_ni,
  input logic              gb0_ni,
  input logic              gb1_ni,
  input logic              od_i,
  input logic              wide_i,
  input logic [N_OUT-1:0]  a_val_o,
  input logic [N_OUT-1:0]  a_drv_o,
  input logic [N_OUT-1:0]  b_val_o,
  input logic [N_OUT-1:0]  b_drv_o
);
  logic [N_OUT-1:0] res_a, res_b;
  assign res_a = a_val_o | ~a_drv_o;
  assign res_b = b_val_o | ~b_drv_o;

  always_comb begin
    AST_A_ONE_LOW_MAX: assert ($onehot0(~res_a)); // R1
    AST_B_ONE_LOW_MAX: assert ($onehot0(~res_b)); // R1
    if (!wide_i && ga_hi_i && !ga_lo_ni && !od_i)
      AST_A_ADDR_LOW: assert (a_val_o[addr_i] == 1'b0); // R1
    if (!wide_i && !(ga_hi_i && !ga_lo_ni))
      AST_A_OFF_HIGH: assert (&res_a); // R2
    if (!wide_i && (gb0_ni || gb1_ni))
      AST_B_OFF_HIGH: assert (&res_b); // R3
    if (!od_i)
      AST_PP_ALL_DRIVEN: assert (&{a_drv_o, b_drv_o}); // R5
    if (od_i)
      AST_OD_NO_HIGH: assert (((a_val_o & a_drv_o) | (b_val_o & b_drv_o)) == '0); // R6
    if (wide_i)
      AST_WIDE_ONE_SIDE: assert (ga_hi_i ? (&res_b) : (&res_a)); // R7
    if (wide_i)
      AST_WIDE_ZERO_CNT: assert ($countones(~{res_a, res_b}) == (ga_lo_ni ? 0 : 1)); // R8
  end
endmodule

bind dual_dec2to4 dual_dec2to4_chk #(.ADDR_W(ADDR_W)) u_chk (
  .addr_i   (addr_i),
  .ga_hi_i  (ga_hi_i),
  .ga_lo_ni (ga_lo_ni),
  .gb0_ni   (gb0_ni),
  .gb1_ni   (gb1_ni),
  .od_i     (od_i),
  .wide_i   (wide_i),
  .a_val_o  (a_val_o),
  .a_drv_o  (a_drv_o),
  .b_val_o  (b_val_o),
  .b_drv_o  (b_drv_o)
);

// File: tb/sim_dual_dec2to4.sv
`timescale 1ns/1ps
module sim_dual_dec2to4;
  logic       clk = 1'b0;
  logic [1:0] addr;
  logic       ga_hi, ga_lo_n, gb0_n, gb1_n, od, wide;
  logic [3:0] a_val, a_drv, b_val, b_drv;

  always #5 clk = ~clk;

  dual_dec2to4 u0 (
    .addr_i   (addr),
    .ga_hi_i  (ga_hi),
    .ga_lo_ni (ga_lo_n),
    .gb0_ni   (gb0_n),
    .gb1_ni   (gb1_n),
    .od_i     (od),
    .wide_i   (wide),
    .a_val_o  (a_val),
    .a_drv_o  (a_drv),
    .b_val_o  (b_val),
    .b_drv_o  (b_drv)
  );

  typedef struct packed {
    logic       pass2;
    logic [7:0] vec;
    logic       a_on;
    logic       b_on;
    logic [3:0] ea_val, ea_drv, eb_val, eb_drv;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lvl(input logic on, input logic [1:0] a);
    return on ? ~(4'b0001 << a) : 4'hF;
  endfunction

  // vec = {wide, od, gb1_n, gb0_n, ga_lo_n, ga_hi, addr[1:0]}
  task automatic drive(input logic [7:0] v, input logic p2);
    item_t it;
    logic [3:0] la, lb;
    @(negedge clk);
    {wide, od, gb1_n, gb0_n, ga_lo_n, ga_hi, addr} = v;
    it.pass2 = p2;
    it.vec   = v;
    it.a_on  = v[2] && !v[3];
    it.b_on  = v[7] ? (!v[2] && !v[3]) : (!v[4] && !v[5]);
    la = lvl(it.a_on, v[1:0]);
    lb = lvl(it.b_on, v[1:0]);
    it.ea_val = v[6] ? 4'h0 : la;
    it.ea_drv = v[6] ? ~la  : 4'hF;
    it.eb_val = v[6] ? 4'h0 : lb;
    it.eb_drv = v[6] ? ~lb  : 4'hF;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic [3:0] ra, rb;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        it = q.pop_front();
        ra = a_val | ~a_drv;
        rb = b_val | ~b_drv;
        chk(it.pass2 ? "R9" : (it.vec[7] ? "R7" : "R2"),
            {24'h0, a_val, a_drv}, {24'h0, it.ea_val, it.ea_drv});
        chk(it.pass2 ? "R9" : (it.vec[7] ? "R7" : "R3"),
            {24'h0, b_val, b_drv}, {24'h0, it.eb_val, it.eb_drv});
        if (!it.vec[6]) chk("R5", {24'h0, a_drv, b_drv}, 32'hFF);
        else            chk("R6", {28'h0, a_val | b_val}, 32'h0);
        if (it.a_on && !it.vec[6] && !it.vec[7])
          chk("R1", {30'h0, a_val[it.vec[1:0]], 1'b0} | $countones(a_val), 32'h3);
        if (!it.a_on) chk("R4", {28'h0, ra}, 32'hF);
        if (!it.b_on) chk("R4", {28'h0, rb}, 32'hF);
        if (it.vec[7])
          chk("R8", $countones(~{ra, rb}), it.vec[3] ? 0 : 1);
      end
    end
  end

  initial begin : driver
    for (int v = 0; v < 256; v++) drive(8'(v), 1'b0);
    for (int v = 255; v >= 0; v--) drive(8'(v), 1'b1);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule